// File: doc/BRIEF.md
# Track/Reset Pulse-Width Discriminator

This block watches one active-low control input that has two jobs. The block decides which job is meant from how long each low pulse lasts. It first brings the raw input into the system clock domain. It then counts how many clock cycles the synchronized level stays low. When the level returns high, it places the pulse in one of three width bands. A pulse that is too short is treated as noise and dropped. A pulse that falls inside the middle band produces a single-cycle reset strobe, which the chip uses as its power-on reset. A low level that outlasts the middle band is a hold. While a hold is in progress, a level output tells the acquisition logic to pass the input voltage straight through and not start a conversion. When the hold ends, a one-cycle strobe tells the sequencer to begin acquisition on the selected channel.

When the input sits high or floats, the block is idle. In that state, addressing a channel starts acquisition at once, and nothing here interferes. Both width limits are parameters counted in clock cycles. The defaults are 9 and 20 cycles, which at a 100 MHz clock correspond to roughly 90 ns and 200 ns. The width counter saturates just above the upper limit, so a hold of any length fits in a few bits.

Top module: `tpd_discriminator`

## Requirements
- R1: During and directly after the synchronous reset `rst`, `reset_pulse`, `track_low` and `track_rise` are all 0, whatever level `pin_n` has.
- R2: `pin_n` passes through SYNC_STAGES flops (default 2) before its width is measured. A pulse that holds `pin_n` at 0 for N rising clock edges has width N. Its `reset_pulse` or `track_rise` strobe is visible in the clock cycle that begins with the (SYNC_STAGES+1)-th rising edge after `pin_n` returns to 1.
- R3: A low pulse of width N < MIN_CYC produces no `reset_pulse`, no `track_rise` and no `track_low`.
- R4: A low pulse with MIN_CYC <= N <= MAX_CYC produces exactly one `reset_pulse`, and that pulse is 1 for exactly one cycle. This includes the boundary widths MIN_CYC and MAX_CYC.
- R5: A low level of width N > MAX_CYC holds `track_low` at 1 for exactly N - MAX_CYC cycles. It then produces one single-cycle `track_rise`, which is 1 in the same cycle that `track_low` returns to 0.
- R6: `reset_pulse` and `track_low` are never 1 together, and `reset_pulse` and `track_rise` are never 1 together. A hold therefore never triggers a reset, and a reset-band pulse never shows a hold.
- R7: The internal width count saturates at MAX_CYC+1. A hold far longer than MAX_CYC (several hundred cycles) still yields exactly one `track_rise`, no `reset_pulse`, and N - MAX_CYC cycles of `track_low`.
- R8: Consecutive low pulses separated by a single high clock cycle are each classified on their own width. The classification of one pulse does not alter the width count of the next.
- R9: While `pin_n` stays at 1, all three outputs stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the discriminator |
| pin_n | input | 1 | Raw active-low track/reset input, asynchronous to clk |
| reset_pulse | output | 1 | One-cycle global reset strobe for a reset-band pulse |
| track_low | output | 1 | High while a low level longer than the reset band is held |
| track_rise | output | 1 | One-cycle strobe when a hold ends; starts acquisition |

## Verification
Two events land in the same cycle when a hold ends: `track_low` drops and `track_rise` fires. A second coincidence occurs when one pulse is classified on the very edge where the next pulse's width count begins. The bench provokes the first by sweeping every width up to five cycles past the upper limit. For each width it counts `track_low` cycles against N - MAX_CYC and confirms a single strobe. It provokes the second by separating pulses with a single high cycle, and it judges the result by the total number of reset and track strobes across the pair, each computed from its own width.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    typedef enum logic [1:0] {
        PW_NONE,
        PW_GLITCH,
        PW_RESET,
        PW_HOLD
    } pw_class_e;

    typedef struct packed {
        logic reset_pulse;
        logic track_rise;
    } pw_event_s;

    // Width in synchronized low samples -> band.
    function automatic pw_class_e pw_classify(input int unsigned width,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (width == 0)
            return PW_NONE;
        else if (width < lo)
            return PW_GLITCH;
        else if (width <= hi)
            return PW_RESET;
        else
            return PW_HOLD;
    endfunction

    function automatic pw_event_s pw_event(input pw_class_e cls);
        pw_event_s ev;
        ev.reset_pulse = (cls == PW_RESET);
        ev.track_rise  = (cls == PW_HOLD);
        return ev;
    endfunction

endpackage

// File: rtl/tpd_sync.sv
module tpd_sync #(
    parameter int unsigned STAGES = 2,
    parameter bit          IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= IDLE;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= {STAGES{IDLE}};
                else     sh <= {sh[STAGES-2:0], d};
            end
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tpd_width_ctr.sv
module tpd_width_ctr #(
    parameter int unsigned MAX_CYC = 20,
    parameter int unsigned CW      = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] SAT = CW'(MAX_CYC + 1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (lvl)
            cnt <= '0;
        else if (cnt != SAT)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tpd_classifier.sv
module tpd_classifier
    import tpd_pkg::*;
#(
    parameter int unsigned MIN_CYC = 9,
    parameter int unsigned MAX_CYC = 20,
    parameter int unsigned CW      = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl,
    input  logic [CW-1:0] cnt,
    output logic          reset_pulse,
    output logic          track_rise
);
    logic      rise;
    pw_class_e cls;
    pw_event_s ev;

    always_comb begin
        rise = lvl && (cnt != '0);
        cls  = rise ? pw_classify(32'(cnt), MIN_CYC, MAX_CYC) : PW_NONE;
        ev   = pw_event(cls);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_pulse <= 1'b0;
            track_rise  <= 1'b0;
        end else begin
            reset_pulse <= ev.reset_pulse;
            track_rise  <= ev.track_rise;
        end
    end
endmodule

// File: rtl/tpd_discriminator.sv
module tpd_discriminator #(
    parameter int unsigned MIN_CYC     = 9,
    parameter int unsigned MAX_CYC     = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic reset_pulse,
    output logic track_low,
    output logic track_rise
);
    localparam int unsigned CW = $clog2(MAX_CYC + 2);
    localparam logic [CW-1:0] SAT = CW'(MAX_CYC + 1);

    logic          pin_s;
    logic [CW-1:0] low_cnt;

    tpd_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_n),
        .q   (pin_s)
    );

    tpd_width_ctr #(.MAX_CYC(MAX_CYC), .CW(CW)) u_ctr (
        .clk (clk),
        .rst (rst),
        .lvl (pin_s),
        .cnt (low_cnt)
    );

    tpd_classifier #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .CW(CW)) u_cls (
        .clk         (clk),
        .rst         (rst),
        .lvl         (pin_s),
        .cnt         (low_cnt),
        .reset_pulse (reset_pulse),
        .track_rise  (track_rise)
    );

    // Hold is visible once the low run has passed the reset band.
    assign track_low = (low_cnt == SAT);
endmodule

// File: rtl/tpd_checker.sv
module tpd_checker #(
    parameter int unsigned MAX_CYC = 20,
    parameter int unsigned CW      = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          reset_pulse,
    input logic          track_low,
    input logic          track_rise,
    input logic [CW-1:0] cnt
);
    // R4
    a_r4_reset_one_cycle: assert property (@(posedge clk) disable iff (rst)
        reset_pulse |=> !reset_pulse);

    // R6
    a_r6_no_reset_in_hold: assert property (@(posedge clk) disable iff (rst)
        track_low |-> !reset_pulse);

    // R6
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reset_pulse && track_rise));

    // R5
    a_r5_release_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(track_low) |-> track_rise);

    // R5
    a_r5_rise_follows_hold: assert property (@(posedge clk) disable iff (rst)
        track_rise |-> $past(track_low));

    // R7
    a_r7_count_saturates: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) <= MAX_CYC + 1);
endmodule

bind tpd_discriminator tpd_checker #(.MAX_CYC(MAX_CYC), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reset_pulse (reset_pulse),
    .track_low   (track_low),
    .track_rise  (track_rise),
    .cnt         (low_cnt)
);

// File: tb/tb_tpd_discriminator.sv
`timescale 1ns/1ps
module tb_tpd_discriminator;
    localparam int MINC = 9;
    localparam int MAXC = 20;
    localparam int LAT  = 3;   // two sync flops + output register

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_n = 1'b1;
    logic reset_pulse, track_low, track_rise;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int c_rst, c_rise, c_low, since_rel, at_rst, at_rise;

    always #2 clk = ~clk;

    tpd_discriminator dut (
        .clk (clk), .rst (rst), .pin_n (pin_n),
        .reset_pulse (reset_pulse), .track_low (track_low), .track_rise (track_rise)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        c_rst = 0; c_rise = 0; c_low = 0; since_rel = 0; at_rst = -1; at_rise = -1;
    endtask

    task automatic step();
        @(negedge clk);
        since_rel++;
        if (reset_pulse) begin c_rst++;  at_rst  = since_rel; end
        if (track_rise)  begin c_rise++; at_rise = since_rel; end
        if (track_low)   c_low++;
    endtask

    task automatic hold(input bit lvl, input int n);
        if (lvl && !pin_n) since_rel = 0;
        pin_n = lvl;
        repeat (n) step();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clr();
        // R1: reset state with the input low
        pin_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 reset_pulse", int'(reset_pulse), 0);
        check("R1 track_low", int'(track_low), 0);
        check("R1 track_rise", int'(track_rise), 0);
        pin_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", int'(reset_pulse | track_low | track_rise), 0);

        // R9: idle high
        clr();
        hold(1, 40);
        check("R9 idle strobes", c_rst + c_rise, 0);
        check("R9 idle hold", c_low, 0);

        // R2..R5: sweep every width
        for (int n = 1; n <= MAXC + 5; n++) begin
            int er, et, el;
            clr();
            hold(0, n);
            hold(1, 8);
            er = (n >= MINC && n <= MAXC) ? 1 : 0;
            et = (n > MAXC) ? 1 : 0;
            el = (n > MAXC) ? n - MAXC : 0;
            if (n < MINC) check("R3 glitch ignored", c_rst + c_rise + c_low, 0);
            check("R4 reset count", c_rst, er);
            check("R5 rise count", c_rise, et);
            check("R5 hold cycles", c_low, el);
            if (er == 1) check("R2 reset latency", at_rst, LAT);
            if (et == 1) check("R2 rise latency", at_rise, LAT);
            check("R6 no reset in hold", (et == 1) ? c_rst : c_low, 0);
        end

        // R7: very long hold
        clr();
        hold(0, 300);
        hold(1, 8);
        check("R7 long rise", c_rise, 1);
        check("R7 long reset", c_rst, 0);
        check("R7 long hold cycles", c_low, 300 - MAXC);

        // R8: single-cycle gaps between pulses
        clr();
        hold(0, 12); hold(1, 1); hold(0, 25); hold(1, 8);
        check("R8 reset then hold rst", c_rst, 1);
        check("R8 reset then hold rise", c_rise, 1);
        check("R8 reset then hold cycles", c_low, 25 - MAXC);
        clr();
        hold(0, MINC - 1); hold(1, 1); hold(0, MINC); hold(1, 8);
        check("R8 glitch then reset", c_rst, 1);
        clr();
        hold(0, MAXC); hold(1, 1); hold(0, MINC); hold(1, 8);
        check("R8 two resets", c_rst, 2);
        check("R8 two resets no hold", c_low + c_rise, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule